// File: doc/BRIEF.md
# Four-Channel External Interrupt Detector

This block watches four asynchronous interrupt pins and turns each into a sticky pending flag that drives one interrupt request line per channel toward an interrupt controller. Every channel is configured on its own: it can be level-sensitive or edge-sensitive, and it can be high or low active (rising or falling edge in edge mode). Each pin first passes through a two-stage synchronizer. All detection works on the synchronized value.

Software uses a small write/read register interface. One register shows the pending flags and clears them when ones are written to it. One register selects level or edge detection per channel. One register selects the polarity per channel. Reads are combinational from the selected address. Writes take effect at the next rising clock edge.

Top module: `extIrqDetect`

## Requirements
- R1: After reset, all flags, mode bits and polarity bits read 0, and `irqReq` is 0.
- R2: The register address selects the register: 0 is the flag register, 1 is the mode register, 2 is the polarity register, and 3 reads 0. Bit i of each register belongs to channel i. Mode and polarity writes read back the value written.
- R3: A mode bit of 0 selects level detection. A polarity bit of 0 makes the pin active low, and 1 makes it active high. The flag is set at the third rising clock edge after the pin reaches its active level.
- R4: A mode bit of 1 selects edge detection. A polarity bit of 1 selects the rising edge and 0 the falling edge. The flag is set at the third rising edge after the selected transition. The opposite transition and a steady active level set nothing.
- R5: `irqReq[i]` equals flag bit i at all times.
- R6: Writing the flag register clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R7: In level mode, a clear write has no effect while the synchronized pin is at its active level.
- R8: A set flag stays 1 until it is cleared, through pin returns to inactive and through further events.
- R9: If a detected event and a clear write for the same channel fall in the same cycle, the flag ends up 1.
- R10: A write to the mode or polarity register does not itself produce an edge event. With the pin held steady, the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 4 | Asynchronous interrupt pins, one per channel |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | 4 | Write data, one bit per channel |
| regRdData | output | 4 | Read data of the addressed register |
| irqReq | output | 4 | Interrupt request per channel |

## Verification
The pin path has three registers in it: two synchronizer stages and the flag. So a flag, and the request it drives, must be 0 after the second rising edge that follows a pin change and 1 after the third. The bench changes pins at a falling edge and counts falling edges to read at exactly those two points. Register writes are applied across one rising edge. Their results are read back combinationally at the next falling edge. For the same-cycle case, the clear write is placed on the third edge after the pin change, which is the edge where the set lands.

// File: rtl/eirqPkg.sv
package eirqPkg;

  typedef enum logic [1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_MODE = 2'd1,
    ADDR_POL  = 2'd2,
    ADDR_RSVD = 2'd3
  } regAddrE;

  typedef struct packed {
    logic flagWr;
    logic modeWr;
    logic polWr;
  } ctlStrobeT;

endpackage

// File: rtl/eirqSync.sv
module eirqSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/eirqCtl.sv
module eirqCtl
  import eirqPkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [NUM_CH-1:0] regWrData,
  input  logic [NUM_CH-1:0] flagVal,
  output ctlStrobeT         strb,
  output logic [NUM_CH-1:0] modeReg,
  output logic [NUM_CH-1:0] polReg,
  output logic [NUM_CH-1:0] regRdData
);

  regAddrE addrSel;
  assign addrSel = regAddrE'(regAddr);

  always_comb begin
    strb.flagWr = regWrEn && (addrSel == ADDR_FLAG);
    strb.modeWr = regWrEn && (addrSel == ADDR_MODE);
    strb.polWr  = regWrEn && (addrSel == ADDR_POL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      polReg  <= '0;
    end else begin
      if (strb.modeWr) modeReg <= regWrData;
      if (strb.polWr)  polReg  <= regWrData;
    end
  end

  always_comb begin
    unique case (addrSel)
      ADDR_FLAG: regRdData = flagVal;
      ADDR_MODE: regRdData = modeReg;
      ADDR_POL:  regRdData = polReg;
      default:   regRdData = '0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.flagWr, strb.modeWr, strb.polWr}));  // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.modeWr |=> $stable(modeReg));  // R2
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.polWr |=> $stable(polReg));  // R2

endmodule

// File: rtl/eirqDatapath.sv
module eirqDatapath
  import eirqPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinIn,
  input  ctlStrobeT         strb,
  input  logic [NUM_CH-1:0] wrData,
  input  logic [NUM_CH-1:0] modeReg,
  input  logic [NUM_CH-1:0] polReg,
  output logic [NUM_CH-1:0] flags
);

  localparam int LEVEL_ARM = SYNC_STAGES;
  localparam int EDGE_ARM  = SYNC_STAGES + 1;
  localparam int ARM_W     = $clog2(EDGE_ARM + 1);

  logic [NUM_CH-1:0] syncPin;
  logic [NUM_CH-1:0] prevPin;
  logic [NUM_CH-1:0] setVec;
  logic [NUM_CH-1:0] clrVec;
  logic [NUM_CH-1:0] edgeHit;
  logic [ARM_W-1:0]  armCnt;
  logic              levelOk;
  logic              edgeOk;
  logic              cfgWr;

  eirqSync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (syncPin)
  );

  // Counts edges after reset until the synchronizer and previous sample are valid.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          armCnt <= '0;
    else if (armCnt != ARM_W'(EDGE_ARM)) armCnt <= armCnt + 1'b1;
  end

  assign levelOk = armCnt >= ARM_W'(LEVEL_ARM);
  assign edgeOk  = armCnt == ARM_W'(EDGE_ARM);
  assign cfgWr   = strb.modeWr | strb.polWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '0;
    else       prevPin <= syncPin;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic nowActive;
    logic wasActive;
    logic clrReq;

    assign nowActive = ~(syncPin[i] ^ polReg[i]);
    assign wasActive = ~(prevPin[i] ^ polReg[i]);
    // A configuration write suppresses edge detection for that cycle.
    assign edgeHit[i] = edgeOk & ~cfgWr & nowActive & ~wasActive;
    assign setVec[i]  = modeReg[i] ? edgeHit[i] : (levelOk & nowActive);
    assign clrReq     = strb.flagWr & wrData[i];
    assign clrVec[i]  = clrReq & ~(~modeReg[i] & nowActive);

    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rstN)
      (!modeReg[i] && levelOk && (syncPin[i] == polReg[i])) |=> flags[i]);  // R3
    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rstN)
      (modeReg[i] && edgeOk && !cfgWr && (syncPin[i] != prevPin[i])
        && (syncPin[i] == polReg[i])) |=> flags[i]);  // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !clrReq) |=> flags[i]);  // R8
    AST_LEVEL_CLR_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !modeReg[i] && (syncPin[i] == polReg[i])) |=> flags[i]);  // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (clrReq && edgeHit[i] && modeReg[i]) |=> flags[i]);  // R9
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWr && modeReg[i] && !flags[i]) |=> !flags[i]);  // R10
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= setVec | (flags & ~clrVec);
  end

endmodule

// File: rtl/extIrqDetect.sv
module extIrqDetect
  import eirqPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinIn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [NUM_CH-1:0] regWrData,
  output logic [NUM_CH-1:0] regRdData,
  output logic [NUM_CH-1:0] irqReq
);

  ctlStrobeT         strb;
  logic [NUM_CH-1:0] modeReg;
  logic [NUM_CH-1:0] polReg;
  logic [NUM_CH-1:0] flags;

  eirqCtl #(.NUM_CH(NUM_CH)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .flagVal   (flags),
    .strb      (strb),
    .modeReg   (modeReg),
    .polReg    (polReg),
    .regRdData (regRdData)
  );

  eirqDatapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strb    (strb),
    .wrData  (regWrData),
    .modeReg (modeReg),
    .polReg  (polReg),
    .flags   (flags)
  );

  assign irqReq = flags;

endmodule

// File: tb/extIrqDetect_bench.sv
`timescale 1ns/1ps
module extIrqDetect_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pinIn = 4'hF;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [3:0] regWrData = 4'h0;
  logic [3:0] regRdData;
  logic [3:0] irqReq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  extIrqDetect u_extIrqDetect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R1 flags in reset", v, 4'h0);
    check("R1 irq in reset", irqReq, 4'h0);
    rstN = 1'b1;
    idle(6);
    rd(2'd0, v); check("R1 flags after reset", v, 4'h0);
    rd(2'd1, v); check("R1 mode after reset", v, 4'h0);
    rd(2'd2, v); check("R1 polarity after reset", v, 4'h0);
    rd(2'd3, v); check("R2 reserved address", v, 4'h0);
    check("R1 irq after reset", irqReq, 4'h0);

    for (int ch = 0; ch < 4; ch++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          logic [3:0] chBit;
          logic act;
          chBit = 4'(1 << ch);
          act = 1'(p);
          pinIn = 4'hF;
          pinIn[ch] = ~act;
          wr(2'd1, (m != 0) ? chBit : 4'h0);
          wr(2'd2, (p != 0) ? chBit : 4'h0);
          idle(5);
          wr(2'd0, 4'hF);
          rd(2'd0, v); check("R6 clear all", v, 4'h0);
          rd(2'd1, v); check("R2 mode readback", v, (m != 0) ? chBit : 4'h0);
          rd(2'd2, v); check("R2 polarity readback", v, (p != 0) ? chBit : 4'h0);

          @(negedge clk); pinIn[ch] = act;
          idle(2);
          rd(2'd0, v); check((m != 0) ? "R4 not before third edge" : "R3 not before third edge", v, 4'h0);
          @(negedge clk);
          rd(2'd0, v); check((m != 0) ? "R4 edge sets flag" : "R3 level sets flag", v, chBit);
          check("R5 irq follows flag", irqReq, chBit);

          if (m == 0) begin
            wr(2'd0, ~chBit);
            rd(2'd0, v); check("R6 zero bit leaves flag", v, chBit);
            wr(2'd0, chBit);
            rd(2'd0, v); check("R7 clear blocked while active", v, chBit);
            pinIn[ch] = ~act;
            idle(4);
            rd(2'd0, v); check("R8 flag sticky after release", v, chBit);
            wr(2'd0, chBit);
            rd(2'd0, v); check("R6 clear when inactive", v, 4'h0);
            check("R5 irq low after clear", irqReq, 4'h0);
          end else begin
            wr(2'd0, chBit);
            rd(2'd0, v); check("R6 clear in edge mode", v, 4'h0);
            idle(4);
            rd(2'd0, v); check("R4 held level no retrigger", v, 4'h0);
            pinIn[ch] = ~act;
            idle(4);
            rd(2'd0, v); check("R4 opposite edge ignored", v, 4'h0);
            @(negedge clk); pinIn[ch] = act;
            idle(2);
            regWrEn = 1'b1; regAddr = 2'd0; regWrData = chBit;
            @(negedge clk);
            regWrEn = 1'b0; regWrData = 4'h0;
            rd(2'd0, v); check("R9 set wins over clear", v, chBit);
            pinIn[ch] = ~act;
            @(negedge clk); pinIn[ch] = act;
            idle(4);
            rd(2'd0, v); check("R8 sticky across new event", v, chBit);
            pinIn[ch] = ~act;
            idle(4);
            wr(2'd0, chBit);
            rd(2'd0, v); check("R6 clear after sticky", v, 4'h0);
            wr(2'd2, (p != 0) ? 4'h0 : chBit);
            idle(4);
            rd(2'd0, v); check("R10 polarity flip no event", v, 4'h0);
            wr(2'd2, (p != 0) ? chBit : 4'h0);
            idle(4);
            rd(2'd0, v); check("R10 polarity restore no event", v, 4'h0);
          end
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired (all requirements): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule